// File: doc/BRIEF.md
# Flash Operation Status Model

This block is a synthesizable stand-in for the status-read side of a small flash bank. It is the device under test for a polling controller. It holds a small word array, which erases to all ones. It accepts three kinds of start: program one word, erase one sector, or erase the whole array. It also accepts a reset command. While an operation is running, each read returns a status byte instead of array data. The bits of that byte change on read accesses, not on clocks.

The controller starts a command with a one-cycle `cmd_valid` pulse. It then polls with `rd_en`. It decides the operation has finished when two back-to-back status reads show an unchanged toggle bit. A program that tries to turn a stored 0 into a 1 stalls. After a pulse limit it raises a sticky timeout flag, and only a reset command clears that flag. Each read is answered one cycle after `rd_en`, on `rd_data` together with `rd_valid`.

States:
- READY: array reads.
- PROG: program running.
- PSTALL: over-program stall.
- FAILED: timeout reached.
- SERASE: sector erase.
- CERASE: chip erase.

Transitions:
- READY→PROG: program start with no 0→1 bit.
- READY→PSTALL: program start with a 0→1 bit.
- PROG→READY: program done.
- PSTALL→FAILED: pulse limit reached.
- FAILED→READY: reset command.
- READY→SERASE: sector erase start.
- READY→CERASE: chip erase start.
- SERASE→READY and CERASE→READY: erase done.

Top module: `fstat_emu`

## Requirements
- R1: In READY, a read returns the array word at `rd_addr` on the cycle after `rd_en`, with `rd_valid` high for one cycle per read.
- R2: In any state other than READY, a read returns a status byte. Its bit 6 inverts on every status read and never changes between reads.
- R3: Status bit 2 inverts on every status read during SERASE and CERASE. Status reads during PROG, PSTALL and FAILED return bit 2 unchanged.
- R4: A program that would set a stored 0 to 1 enters PSTALL. After PULSE_LIM cycles it enters FAILED, where status bit 5 reads 1. Bit 5 stays 1 until a reset command.
- R5: A program with no 0→1 bit stays busy for PROG_CYC cycles. The word then holds the old word AND the data, and the next read returns array data.
- R6: A stalled program leaves the array unchanged. After the reset command, reads return the original word.
- R7: A sector erase (sector = `cmd_addr[AW-1:SEC_AW]`) runs for ERASE_CYC cycles. Status bit 3 reads 0 while fewer than SE_WIN cycles have passed and 1 after that. At the end every word of that sector reads all ones, and the other sectors are unchanged.
- R8: A chip erase reads status bit 3 as 1 from its first cycle. After ERASE_CYC cycles every word reads all ones.
- R9: Command encoding on `cmd_op`: 00 program, 01 sector erase, 10 chip erase, 11 reset. Commands are acted on only in READY, and there reset does nothing. In FAILED only reset is acted on. All other commands are ignored.
- R10: Status bits 7, 4, 1 and 0 read 0.
- R11: After `rst_n` is low, the block is in READY, every word is all ones, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (R9) |
| cmd_addr | input | AW | Program word address or erase sector address |
| cmd_data | input | DW | Program data |
| rd_en | input | 1 | Read access |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read answer present |
| rd_data | output | DW | Array word or status byte |

## Verification
The hardest case to reach is the over-program timeout. The bench first programs a word so that it holds some zeros. It then issues a program whose data has ones in those positions. It keeps polling past PULSE_LIM cycles, so that the toggle bit is seen still running while bit 5 is high. Inside that failed state it fires ignored program and erase commands before the reset command. It then reads the word back to confirm that nothing was written.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PROG,
        ST_PSTALL,
        ST_FAILED,
        ST_SERASE,
        ST_CERASE
    } fstat_state_e;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_RESET  = 2'b11
    } fstat_op_e;

    localparam int STAT_W   = 8;
    localparam int BIT_TOGA = 6;
    localparam int BIT_TLIM = 5;
    localparam int BIT_ERB  = 3;
    localparam int BIT_TOGB = 2;

endpackage

// File: rtl/fstat_array.sv
module fstat_array #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int SEC_AW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_addr_a,
    output logic [DW-1:0]        rd_word_a,
    input  logic [AW-1:0]        rd_addr_b,
    output logic [DW-1:0]        rd_word_b,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_mask,
    input  logic                 ers_sec_en,
    input  logic [AW-SEC_AW-1:0] ers_sec,
    input  logic                 ers_all
);
    localparam int DEPTH = 1 << AW;
    localparam int SEC_W = AW - SEC_AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[wr_addr] <= mem_q[wr_addr] & wr_mask;
        end else if (ers_all) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (ers_sec_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (SEC_W'(i >> SEC_AW) == ers_sec) mem_q[i] <= '1;
        end
    end

    assign rd_word_a = mem_q[rd_addr_a];
    assign rd_word_b = mem_q[rd_addr_b];

endmodule

// File: rtl/fstat_ctrl.sv
module fstat_ctrl
    import fstat_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int SEC_AW    = 2,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    parameter int SE_WIN    = 5,
    parameter int PULSE_LIM = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [AW-1:0]        cmd_addr,
    input  logic [DW-1:0]        cmd_data,
    input  logic [DW-1:0]        cur_word,
    input  logic                 rd_en,
    output logic                 busy,
    output logic                 in_erase,
    output logic                 in_chip,
    output logic [STAT_W-1:0]    status,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [DW-1:0]        wr_mask,
    output logic                 ers_sec_en,
    output logic [AW-SEC_AW-1:0] ers_sec,
    output logic                 ers_all
);
    localparam int MAXC = (ERASE_CYC > PULSE_LIM) ? ERASE_CYC : PULSE_LIM;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ERS_LAST  = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] LIM_LAST  = CW'(PULSE_LIM - 1);
    localparam logic [CW-1:0] WIN_CNT   = CW'(SE_WIN);

    fstat_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] adr_q;
    logic [DW-1:0] dat_q;
    logic          tog6_q, tog2_q;
    fstat_op_e     op;
    logic          accept;

    assign op     = fstat_op_e'(cmd_op);
    assign accept = (state_q == ST_READY) && cmd_valid;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                cnt_d = '0;
                if (cmd_valid) begin
                    unique case (op)
                        OP_PROG:   state_d = |(cmd_data & ~cur_word) ? ST_PSTALL : ST_PROG;
                        OP_SERASE: state_d = ST_SERASE;
                        OP_CERASE: state_d = ST_CERASE;
                        OP_RESET:  state_d = ST_READY;
                    endcase
                end
            end
            ST_PROG:
                if (cnt_q == PROG_LAST) state_d = ST_READY;
                else cnt_d = cnt_q + 1'b1;
            ST_PSTALL:
                if (cnt_q == LIM_LAST) state_d = ST_FAILED;
                else cnt_d = cnt_q + 1'b1;
            ST_FAILED:
                if (cmd_valid && op == OP_RESET) state_d = ST_READY;
            ST_SERASE, ST_CERASE:
                if (cnt_q == ERS_LAST) state_d = ST_READY;
                else cnt_d = cnt_q + 1'b1;
            default: state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
            adr_q   <= '0;
            dat_q   <= '0;
            tog6_q  <= 1'b0;
            tog2_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                adr_q <= cmd_addr;
                dat_q <= cmd_data;
            end
            if (rd_en && busy)     tog6_q <= ~tog6_q;
            if (rd_en && in_erase) tog2_q <= ~tog2_q;
        end
    end

    // output process
    always_comb begin
        busy       = (state_q != ST_READY);
        in_erase   = (state_q == ST_SERASE) || (state_q == ST_CERASE);
        in_chip    = (state_q == ST_CERASE);
        wr_en      = (state_q == ST_PROG) && (cnt_q == PROG_LAST);
        wr_addr    = adr_q;
        wr_mask    = dat_q;
        ers_sec_en = (state_q == ST_SERASE) && (cnt_q == ERS_LAST);
        ers_sec    = adr_q[AW-1:SEC_AW];
        ers_all    = (state_q == ST_CERASE) && (cnt_q == ERS_LAST);
        status     = '0;
        status[BIT_TOGA] = tog6_q;
        status[BIT_TLIM] = (state_q == ST_FAILED);
        status[BIT_TOGB] = tog2_q;
        status[BIT_ERB]  = in_chip || ((state_q == ST_SERASE) && (cnt_q >= WIN_CNT));
    end

    AST_FAIL_FROM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_FAILED) |-> $past(state_q) == ST_PSTALL); // R4
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PSTALL || state_q == ST_FAILED) |-> !wr_en); // R6
    AST_FAIL_ONLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && !(cmd_valid && cmd_op == 2'b11)) |=> state_q == ST_FAILED); // R9

endmodule

// File: rtl/fstat_emu.sv
module fstat_emu
    import fstat_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int SEC_AW    = 2,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    parameter int SE_WIN    = 5,
    parameter int PULSE_LIM = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0]        arr_word, cur_word, wr_mask;
    logic [STAT_W-1:0]    status;
    logic                 busy, in_erase, in_chip, wr_en, ers_sec_en, ers_all;
    logic [AW-1:0]        wr_addr;
    logic [AW-SEC_AW-1:0] ers_sec;

    fstat_array #(.DW(DW), .AW(AW), .SEC_AW(SEC_AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr), .rd_word_a(arr_word),
        .rd_addr_b(cmd_addr), .rd_word_b(cur_word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .ers_sec_en(ers_sec_en), .ers_sec(ers_sec), .ers_all(ers_all)
    );

    fstat_ctrl #(
        .DW(DW), .AW(AW), .SEC_AW(SEC_AW), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .SE_WIN(SE_WIN), .PULSE_LIM(PULSE_LIM)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cur_word(cur_word), .rd_en(rd_en),
        .busy(busy), .in_erase(in_erase), .in_chip(in_chip), .status(status),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .ers_sec_en(ers_sec_en), .ers_sec(ers_sec), .ers_all(ers_all)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= busy ? DW'(status) : arr_word;
        end
    end

    AST_TOGA_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> rd_data[6] != $past(rd_data[6])); // R2
    AST_TOGB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !in_erase && $past(rd_en && busy && !in_erase))
        |=> rd_data[2] == $past(rd_data[2])); // R3
    AST_CHIP_ERB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_chip) |=> rd_data[3]); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_data[7] == 1'b0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00)); // R10

endmodule

// File: tb/fstat_emu_test.sv
`timescale 1ns/1ps
module fstat_emu_test;
    localparam int DW = 8, AW = 4, SEC_AW = 2;
    localparam int PROG_CYC = 6, ERASE_CYC = 20, SE_WIN = 5, PULSE_LIM = 12;
    localparam int DEPTH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic rd_en = 1'b0;
    logic rd_valid;
    logic [DW-1:0] rd_data;

    fstat_emu #(.DW(DW), .AW(AW), .SEC_AW(SEC_AW), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .SE_WIN(SE_WIN), .PULSE_LIM(PULSE_LIM)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data));

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference: 0 ready,1 prog,2 stall,3 failed,4 sector erase,5 chip erase
    int m_st = 0, m_cnt = 0, m_adr = 0;
    logic [7:0] m_dat;
    logic [7:0] m_mem [DEPTH];
    bit m_t6 = 0, m_t2 = 0;
    bit e_valid = 0, e_status = 0;
    logic [7:0] e_data = '0;
    string e_tag = "R11";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_t6 = 0; m_t2 = 0;
            e_valid = 0; e_data = '0; e_status = 0; e_tag = "R11";
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
        end else begin
            e_valid = rd_en;
            if (rd_en) begin
                if (m_st == 0) begin
                    e_data = m_mem[rd_addr]; e_status = 0; e_tag = "R1";
                end else begin
                    e_status = 1;
                    e_data = 8'h00;
                    e_data[6] = m_t6;
                    e_data[5] = (m_st == 3);
                    e_data[3] = (m_st == 5) || (m_st == 4 && m_cnt >= SE_WIN);
                    e_data[2] = m_t2;
                    case (m_st)
                        1: e_tag = "R2";
                        2: e_tag = "R3";
                        3: e_tag = "R4";
                        4: e_tag = "R7";
                        default: e_tag = "R8";
                    endcase
                    m_t6 = !m_t6;
                    if (m_st >= 4) m_t2 = !m_t2;
                end
            end
            case (m_st)
                0: if (cmd_valid) begin
                    m_cnt = 0; m_adr = cmd_addr; m_dat = cmd_data;
                    if (cmd_op == 2'b00) m_st = ((cmd_data & ~m_mem[cmd_addr]) != 0) ? 2 : 1;
                    else if (cmd_op == 2'b01) m_st = 4;
                    else if (cmd_op == 2'b10) m_st = 5;
                end
                1: if (m_cnt == PROG_CYC - 1) begin
                    m_mem[m_adr] = m_mem[m_adr] & m_dat; m_st = 0;
                end else m_cnt++;
                2: if (m_cnt == PULSE_LIM - 1) m_st = 3; else m_cnt++;
                3: if (cmd_valid && cmd_op == 2'b11) m_st = 0;
                default: if (m_cnt == ERASE_CYC - 1) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (m_st == 5 || (i >> SEC_AW) == (m_adr >> SEC_AW)) m_mem[i] = 8'hFF;
                    m_st = 0;
                end else m_cnt++;
            endcase
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (rd_valid !== e_valid) begin
                n_fail++;
                $display("FAIL %s rd_valid actual %0b expected %0b", e_tag, rd_valid, e_valid);
            end else if (e_valid && rd_data !== e_data) begin
                n_fail++;
                $display("FAIL %s rd_data actual %02h expected %02h", e_tag, rd_data, e_data);
            end
            if (e_valid && e_status) begin
                n_tests++;
                if ((rd_data & 8'h93) != 0) begin // R10
                    n_fail++;
                    $display("FAIL R10 reserved bits actual %02h expected 00", rd_data & 8'h93);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input int adr, input logic [7:0] dat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(adr); cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd1(input int adr, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(adr);
        @(negedge clk);
        rd_en = 1'b0; v = rd_data;
    endtask

    task automatic rd2(input int adr, output logic [7:0] v1, output logic [7:0] v2);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(adr);
        @(negedge clk);
        v1 = rd_data;
        @(negedge clk);
        rd_en = 1'b0; v2 = rd_data;
    endtask

    task automatic poll(input int adr, input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en = gap ? (i % 2 == 0) : 1'b1; rd_addr = AW'(adr);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b;
        idle(3);
        chk("R11 rd_valid", {7'b0, rd_valid}, 8'h00);
        chk("R11 rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            rd1(i, a); chk("R11 erased", a, 8'hFF);
        end
        // R5 normal program, R2/R3 toggle behaviour during program
        cmd(2'b00, 3, 8'hA5);
        rd2(3, a, b);
        chk("R2 bit6 changes", {7'b0, a[6] ^ b[6]}, 8'h01);
        chk("R3 bit2 held in program", {7'b0, a[2] ^ b[2]}, 8'h00);
        poll(3, 10, 0);
        rd1(3, a); chk("R5 programmed", a, 8'hA5);
        cmd(2'b00, 3, 8'h05);
        poll(3, 10, 1);
        rd1(3, a); chk("R5 and-programmed", a, 8'h05);
        // R4 over-program stall then timeout
        cmd(2'b00, 3, 8'hF0);
        rd2(3, a, b);
        chk("R4 bit5 low while stalling", {7'b0, a[5]}, 8'h00);
        chk("R2 bit6 changes in stall", {7'b0, a[6] ^ b[6]}, 8'h01);
        poll(3, PULSE_LIM + 2, 0);
        rd2(3, a, b);
        chk("R4 bit5 set", {7'b0, b[5]}, 8'h01);
        chk("R4 still toggling", {7'b0, a[6] ^ b[6]}, 8'h01);
        cmd(2'b00, 4, 8'h00);   // R9 ignored in failed
        cmd(2'b01, 0, 8'h00);   // R9 ignored in failed
        idle(ERASE_CYC + 2);
        rd1(3, a); chk("R9 fail sticky", {7'b0, a[5]}, 8'h01);
        cmd(2'b11, 0, 8'h00);
        rd1(3, a); chk("R6 word unchanged", a, 8'h05);
        rd1(4, a); chk("R9 ignored program", a, 8'hFF);
        cmd(2'b11, 0, 8'h00);   // R9 reset in ready does nothing
        rd1(3, a); chk("R9 reset no effect", a, 8'h05);
        // R7 sector erase
        cmd(2'b00, 9, 8'h3C);
        poll(9, PROG_CYC + 2, 0);
        cmd(2'b01, 1, 8'h00);
        rd1(1, a); chk("R7 bit3 low early", {7'b0, a[3]}, 8'h00);
        cmd(2'b00, 0, 8'h00);   // R9 ignored while busy
        idle(SE_WIN + 2);
        rd2(1, a, b);
        chk("R7 bit3 high", {7'b0, b[3]}, 8'h01);
        chk("R3 bit2 changes in erase", {7'b0, a[2] ^ b[2]}, 8'h01);
        poll(1, ERASE_CYC + 4, 1);
        rd1(3, a); chk("R7 sector erased", a, 8'hFF);
        rd1(0, a); chk("R9 busy program ignored", a, 8'hFF);
        rd1(9, a); chk("R7 other sector kept", a, 8'h3C);
        // R8 chip erase
        cmd(2'b10, 0, 8'h00);
        rd1(9, a); chk("R8 bit3 at once", {7'b0, a[3]}, 8'h01);
        poll(9, ERASE_CYC + 4, 0);
        rd1(9, a); chk("R8 all erased", a, 8'hFF);
        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule